// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block handles interrupts for one peripheral that shares a single interrupt request line with other peripherals. It has three sources: a parallel transfer event, an interval timer event and an active-low external fault input. Each source carries its own programmable 8-bit vector. When a source event arrives, the block records it as pending. If that source is enabled, the block raises a request to the processor.

Several instances form a priority chain. Each instance passes permission down the chain through a priority-out output that feeds the priority-in input of the next instance. An instance that wants service, or is already being serviced, withholds permission from the instances after it. When the processor runs an acknowledge cycle, the permitted instance with an enabled pending source returns the vector of its most urgent source for one cycle. It then holds the chain until the processor sends a low end-of-service pulse. Acknowledging a request does not release the chain.

Top module: `irq_chain_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `intReq` and `vecValid` are 0, `vecOut` is 0, and `prioOut` follows `prioIn`.
- R2: A rising edge on `pioEvt` or on `tmrEvt`, or a falling edge on `faultN`, sets the pending flag of that source at the clock edge where the edge is sampled. A level that stays high or low does not set the flag again.
- R3: A pending flag stays set while its source is disabled. Enabling the source later makes it raise `intReq` with no new event.
- R4: `pioFaultEn` gates both the parallel source and the fault source. `tmrEn` gates only the timer source.
- R5: `intReq` is 1 exactly when at least one enabled source is pending and the block is not in service.
- R6: `prioOut` is 1 exactly when `prioIn` is 1, no enabled source is pending, and the block is not in service.
- R7: When an acknowledge is sampled with `prioIn` high, at least one enabled source pending and the block idle, the next cycle shows `vecValid`=1 for one cycle. In that cycle `vecOut` holds the vector of the winning source. Fault wins over timer, and timer wins over parallel. At all other times `vecOut` is 0.
- R8: An acknowledge sampled while `prioIn` is low, or while no enabled source is pending, has no effect. `vecValid` stays 0 and the pending flags are kept.
- R9: A grant clears only the winning source's pending flag. A new event on that same source in the grant cycle leaves the flag set.
- R10: From a grant until release, the block is in service. In service, `intReq` and `prioOut` are 0 and further acknowledges are ignored.
- R11: `endSvcN` sampled low while in service returns the block to idle at that clock edge. Pending flags are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pioEvt | input | 1 | Parallel transfer event, rising edge |
| tmrEvt | input | 1 | Timer event, rising edge |
| faultN | input | 1 | External fault, falling edge |
| pioFaultEn | input | 1 | Enable for the parallel and fault sources |
| tmrEn | input | 1 | Enable for the timer source |
| vecPio | input | 8 | Vector for the parallel source |
| vecTmr | input | 8 | Vector for the timer source |
| vecFault | input | 8 | Vector for the fault source |
| prioIn | input | 1 | Chain permission from the device before this one, 1 = permitted |
| prioOut | output | 1 | Chain permission to the device after this one |
| ackStrobe | input | 1 | Acknowledge cycle, one clock wide |
| endSvcN | input | 1 | End-of-service pulse, active low |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Granted vector, 0 when not valid |
| vecValid | output | 1 | `vecOut` carries a granted vector |

## Verification
The hardest situation to reach is a grant in the same clock as a fresh edge on the winning source. The stimulus must first arm the parallel source with a pulse and drop the line for one cycle. It then raises the line again in the exact cycle that carries the acknowledge. After the end-of-service pulse, the request must reappear with no further event. A second hard case is a request held back by a low `prioIn` during an acknowledge. The bench lowers `prioIn` around an acknowledge and checks that the vector is withheld and the flag survives.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int SRC_N   = 3;
  localparam int SRC_PIO = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_FLT = 2;

  typedef struct packed {
    logic             grant;
    logic [SRC_N-1:0] clrHot;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_chain_dp.sv
module irq_chain_dp
  import irq_chain_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pioEvt,
  input  logic             tmrEvt,
  input  logic             faultN,
  input  logic             pioFaultEn,
  input  logic             tmrEn,
  input  logic [VEC_W-1:0] vecPio,
  input  logic [VEC_W-1:0] vecTmr,
  input  logic [VEC_W-1:0] vecFault,
  input  ctrlStrobe_t      strobe,
  output logic [SRC_N-1:0] enPend,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);
  logic [SRC_N-1:0] rawLvl, prevLvl, evtHit, pending, enMask;
  logic [VEC_W-1:0] vecArr [SRC_N];
  logic [VEC_W-1:0] vecSel;

  // active-high view of each source line
  always_comb begin
    rawLvl          = '0;
    rawLvl[SRC_PIO] = pioEvt;
    rawLvl[SRC_TMR] = tmrEvt;
    rawLvl[SRC_FLT] = ~faultN;
    enMask          = '0;
    enMask[SRC_PIO] = pioFaultEn;
    enMask[SRC_TMR] = tmrEn;
    enMask[SRC_FLT] = pioFaultEn;
  end

  assign vecArr[SRC_PIO] = vecPio;
  assign vecArr[SRC_TMR] = vecTmr;
  assign vecArr[SRC_FLT] = vecFault;

  assign evtHit = rawLvl & ~prevLvl;
  assign enPend = pending & enMask;

  // one-hot select of the granted vector
  always_comb begin
    vecSel = '0;
    for (int i = 0; i < SRC_N; i++)
      if (strobe.clrHot[i]) vecSel = vecSel | vecArr[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl  <= '0;
      pending  <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      prevLvl  <= rawLvl;
      // a new event wins over the grant clear
      pending  <= (pending & ~strobe.clrHot) | evtHit;
      vecValid <= strobe.grant;
      vecOut   <= strobe.grant ? vecSel : '0;
    end
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] enPend,
  input  logic             prioIn,
  input  logic             ackStrobe,
  input  logic             endSvcN,
  output ctrlStrobe_t      strobe,
  output logic             inSvc,
  output logic             intReq,
  output logic             prioOut
);
  logic             anyPend, grant;
  logic [SRC_N-1:0] winHot;

  assign anyPend = |enPend;

  // highest index is most urgent: fault, then timer, then parallel
  always_comb begin
    winHot = '0;
    for (int i = 0; i < SRC_N; i++)
      if (enPend[i]) winHot = SRC_N'(1) << i;
  end

  assign grant         = ackStrobe & prioIn & anyPend & ~inSvc;
  assign strobe.grant  = grant;
  assign strobe.clrHot = grant ? winHot : '0;

  assign intReq  = anyPend & ~inSvc;
  assign prioOut = prioIn & ~anyPend & ~inSvc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 inSvc <= 1'b0;
    else if (grant)            inSvc <= 1'b1;
    else if (inSvc && !endSvcN) inSvc <= 1'b0;
  end
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
  import irq_chain_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pioEvt,
  input  logic             tmrEvt,
  input  logic             faultN,
  input  logic             pioFaultEn,
  input  logic             tmrEn,
  input  logic [VEC_W-1:0] vecPio,
  input  logic [VEC_W-1:0] vecTmr,
  input  logic [VEC_W-1:0] vecFault,
  input  logic             prioIn,
  output logic             prioOut,
  input  logic             ackStrobe,
  input  logic             endSvcN,
  output logic             intReq,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);
  ctrlStrobe_t      strobe;
  logic [SRC_N-1:0] enPend;
  logic             inSvc;

  irq_chain_dp #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .pioEvt(pioEvt), .tmrEvt(tmrEvt), .faultN(faultN),
    .pioFaultEn(pioFaultEn), .tmrEn(tmrEn), .vecPio(vecPio), .vecTmr(vecTmr),
    .vecFault(vecFault), .strobe(strobe), .enPend(enPend), .vecOut(vecOut),
    .vecValid(vecValid)
  );

  irq_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enPend(enPend), .prioIn(prioIn),
    .ackStrobe(ackStrobe), .endSvcN(endSvcN), .strobe(strobe), .inSvc(inSvc),
    .intReq(intReq), .prioOut(prioOut)
  );
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk (
  input logic clk,
  input logic rstN,
  input logic prioIn,
  input logic prioOut,
  input logic intReq,
  input logic ackStrobe,
  input logic endSvcN,
  input logic vecValid,
  input logic inSvc
);
  a_r6_chain_blocked: assert property (@(posedge clk) disable iff (!rstN)
    !prioIn |-> !prioOut);

  a_r10_service_quiet: assert property (@(posedge clk) disable iff (!rstN)
    inSvc |-> (!intReq && !prioOut));

  a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ($past(ackStrobe) && $past(prioIn)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  a_r10_grant_enters: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> inSvc);

  a_r11_release: assert property (@(posedge clk) disable iff (!rstN)
    (inSvc && !endSvcN) |=> !inSvc);
endmodule

bind irq_chain_top irq_chain_chk u_chk (
  .clk(clk), .rstN(rstN), .prioIn(prioIn), .prioOut(prioOut), .intReq(intReq),
  .ackStrobe(ackStrobe), .endSvcN(endSvcN), .vecValid(vecValid), .inSvc(inSvc)
);

// File: tb/sim_irq_chain_top.sv
module sim_irq_chain_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, pioEvt, tmrEvt, faultN, pioFaultEn, tmrEn, prioIn, ackStrobe, endSvcN;
  logic [7:0] vecPio, vecTmr, vecFault;
  logic prioOut, intReq, vecValid;
  logic [7:0] vecOut;

  // next values, applied at the falling edge
  logic nRst, nPio, nTmr, nFlt, nPfEn, nTEn, nPrio, nAck, nEos;

  // reference state
  bit mPio, mTmr, mFlt, mIn;
  bit pPio, pTmr, pFltN;
  bit mVal;
  int mVec;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  irq_chain_top u0 (
    .clk(clk), .rstN(rstN), .pioEvt(pioEvt), .tmrEvt(tmrEvt), .faultN(faultN),
    .pioFaultEn(pioFaultEn), .tmrEn(tmrEn), .vecPio(vecPio), .vecTmr(vecTmr),
    .vecFault(vecFault), .prioIn(prioIn), .prioOut(prioOut), .ackStrobe(ackStrobe),
    .endSvcN(endSvcN), .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );

  function automatic bit enAny();
    return (mPio && pioFaultEn) || (mFlt && pioFaultEn) || (mTmr && tmrEn);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit busy = mIn;
    chk("intReq", int'(intReq), int'(enAny() && !busy));
    chk("prioOut", int'(prioOut), int'(prioIn && !enAny() && !busy));
    chk("vecValid", int'(vecValid), int'(mVal));
    chk("vecOut", int'(vecOut), mVec);
  endtask

  task automatic modelStep();
    bit fPio, fTmr, fFlt, g;
    int win;
    if (!rstN) begin
      mPio = 0; mTmr = 0; mFlt = 0; mIn = 0; mVal = 0; mVec = 0;
      pPio = 0; pTmr = 0; pFltN = 1;
      return;
    end
    fPio = pioEvt && !pPio;
    fTmr = tmrEvt && !pTmr;
    fFlt = !faultN && pFltN;
    g = ackStrobe && prioIn && enAny() && !mIn;
    win = -1;
    if (g) begin
      if (mFlt && pioFaultEn) win = 2;
      else if (mTmr && tmrEn) win = 1;
      else win = 0;
    end
    mVal = g;
    mVec = (win == 2) ? int'(vecFault) : (win == 1) ? int'(vecTmr) :
           (win == 0) ? int'(vecPio) : 0;
    if (win == 2) mFlt = 0;
    if (win == 1) mTmr = 0;
    if (win == 0) mPio = 0;
    if (fPio) mPio = 1;
    if (fTmr) mTmr = 1;
    if (fFlt) mFlt = 1;
    if (g) mIn = 1;
    else if (mIn && !endSvcN) mIn = 0;
    pPio = pioEvt; pTmr = tmrEvt; pFltN = faultN;
  endtask

  task automatic cyc();
    @(negedge clk);
    rstN = nRst; pioEvt = nPio; tmrEvt = nTmr; faultN = nFlt;
    pioFaultEn = nPfEn; tmrEn = nTEn; prioIn = nPrio; ackStrobe = nAck; endSvcN = nEos;
    #1 compare();
    @(posedge clk);
    modelStep();
  endtask

  task automatic drain();
    nAck = 1; cyc(); nAck = 0; cyc();
    nEos = 0; cyc(); nEos = 1; cyc();
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    vecPio = 8'h21; vecTmr = 8'h42; vecFault = 8'h84;
    rstN = 0; pioEvt = 0; tmrEvt = 0; faultN = 1; pioFaultEn = 0; tmrEn = 0;
    prioIn = 1; ackStrobe = 0; endSvcN = 1;
    nRst = 0; nPio = 0; nTmr = 0; nFlt = 1; nPfEn = 0; nTEn = 0;
    nPrio = 1; nAck = 0; nEos = 1;
    mPio = 0; mTmr = 0; mFlt = 0; mIn = 0; mVal = 0; mVec = 0;
    pPio = 0; pTmr = 0; pFltN = 1;

    tag = "R1 reset";
    repeat (3) cyc();
    nRst = 1; repeat (2) cyc();

    tag = "R2 R5 parallel edge";
    nPfEn = 1; nTEn = 1;
    nPio = 1; cyc(); cyc(); nPio = 0; cyc(); cyc();

    tag = "R7 grant parallel";
    nAck = 1; cyc(); nAck = 0; cyc();

    tag = "R10 in service";
    nTmr = 1; cyc(); nTmr = 0; nAck = 1; cyc(); nAck = 0; cyc();

    tag = "R11 release";
    nEos = 0; cyc(); nEos = 1; cyc();
    drain();

    tag = "R7 local order";
    nFlt = 0; nPio = 1; nTmr = 1; cyc(); nPio = 0; nTmr = 0; cyc();
    for (int k = 0; k < 3; k++) drain();
    nFlt = 1; cyc();

    tag = "R3 R4 gated sources";
    nPfEn = 0; nTEn = 0;
    nPio = 1; nFlt = 0; cyc(); nPio = 0; cyc(); nFlt = 1;
    nTmr = 1; cyc(); nTmr = 0; cyc();
    tag = "R8 ack with nothing enabled";
    nAck = 1; cyc(); nAck = 0; cyc();
    tag = "R4 timer enable only";
    nTEn = 1; cyc(); cyc();
    drain();
    tag = "R3 late enable";
    nPfEn = 1; cyc(); cyc();
    drain(); drain();

    tag = "R8 chain blocked";
    nPio = 1; cyc(); nPio = 0; cyc();
    nPrio = 0; cyc(); nAck = 1; cyc(); nAck = 0; cyc();
    tag = "R6 chain restored";
    nPrio = 1; cyc();
    drain();

    tag = "R9 event during grant";
    nPio = 1; cyc(); nPio = 0; cyc();
    nAck = 1; nPio = 1; cyc(); nAck = 0; nPio = 0; cyc();
    nEos = 0; cyc(); nEos = 1; cyc(); cyc();
    drain();

    tag = "R6 idle chain follow";
    nPrio = 0; cyc(); nPrio = 1; cyc(); cyc();

    finishRun();
  end
endmodule